// File: doc/BRIEF.md
# Codec Power-Down and Wake-Up Sequencer

This block runs the digital side of an audio codec's sleep and wake behaviour. An active-low power-down pin, taken through a synchronizer, holds the converter datapaths in power-down. While it is held, both digital filter resets are asserted and the serial data output is tied low. In master mode the frame clock pin is also held high and the bit clock pin held low. The master clock output keeps running the whole time, because the oscillator is never stopped.

When the pin is released, the DAC path comes back at once. The ADC path waits out an analog settling window, counted in rising edges of the frame clock, and only then lets serial data through. Until that point the ADC output carries zero data. If power-down is asserted again inside the window, the wait is cancelled and starts over from zero on the next release.

A three-state status output (sleep, settling, running) makes each phase visible, so that it can be compared against the frame count. The block comes out of its own reset in the sleep state. A power-down cycle is therefore always applied before normal operation begins.

Top module: `codec_pd_seq`

## Requirements
- R1: While rst_ni is low, state_o reads 0, adc_filt_rst_o and dac_filt_rst_o are 1, dac_en_o and adc_valid_o are 0, and sdto_o is 0 whatever sdto_i is.
- R2: pdn_ni passes through a two-stage synchronizer. At most four clocks after pdn_ni goes low from the running state, state_o reads 0, both filter resets are 1 and dac_en_o is 0.
- R3: sdto_o is 0 whenever adc_valid_o is 0, that is in states 0 and 1. In state 2 it equals sdto_i.
- R4: After release, adc_valid_o stays 0 through 515 rising edges of lrck_i counted in state 1. It rises within two clocks of the 516th rising edge, and state_o then reads 2.
- R5: As soon as state_o reads 1, dac_en_o is 1 and dac_filt_rst_o is 0, while adc_filt_rst_o is also 0 and adc_valid_o is still 0.
- R6: With master_i=1 and state_o=0, lrck_o is 1 and bclk_o is 0. In states 1 and 2, lrck_o and bclk_o follow lrck_i and bclk_i.
- R7: With master_i=0, lrck_o and bclk_o follow lrck_i and bclk_i in every state, and clk_oe_o is 0. With master_i=1, clk_oe_o is 1.
- R8: mclk_o equals mclk_i in every state, including state 0.
- R9: Driving pdn_ni low during state 1 returns state_o to 0. After the next release, a full 516 frame edges are needed again before adc_valid_o rises.
- R10: The state_o encoding is 0 = power-down, 1 = initialization, 2 = normal. State 2 is entered only from state 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pdn_ni | input | 1 | Power-down pin, active low, asynchronous |
| master_i | input | 1 | 1 = master mode (block drives frame and bit clock pins) |
| mclk_i | input | 1 | Master clock from the oscillator |
| lrck_i | input | 1 | Frame clock, synchronous to clk_i |
| bclk_i | input | 1 | Bit clock, synchronous to clk_i |
| sdto_i | input | 1 | Raw ADC serial data |
| mclk_o | output | 1 | Master clock output, never gated |
| lrck_o | output | 1 | Frame clock pin level |
| bclk_o | output | 1 | Bit clock pin level |
| clk_oe_o | output | 1 | Output enable for the frame and bit clock pins |
| sdto_o | output | 1 | ADC serial data pin level |
| adc_filt_rst_o | output | 1 | ADC digital filter reset, active high |
| dac_filt_rst_o | output | 1 | DAC digital filter reset, active high |
| dac_en_o | output | 1 | DAC path enable |
| adc_valid_o | output | 1 | ADC settling window complete |
| state_o | output | 2 | Sequencer state: 0 power-down, 1 init, 2 normal |

## Verification
The hardest case to reach is a power-down that arrives part way through the settling window, followed by a restart. Only then does the count have to go back to zero instead of resuming. The stimulus releases the pin and delivers 300 frame edges. It then pulls the pin low long enough for the synchronizer to pass it, and releases again. The bench then delivers exactly 515 edges and checks that the block is still settling, and only the 516th edge may bring it to normal. The same 515/516 boundary is checked on the first wake-up, with lrck_i driven edge by edge from the bench.

// File: rtl/codec_pd_pkg.sv
package codec_pd_pkg;
  typedef enum logic [1:0] {
    ST_PD     = 2'd0,
    ST_INIT   = 2'd1,
    ST_NORMAL = 2'd2
  } pd_state_e;
endpackage

// File: rtl/pd_sync.sv
module pd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= {sr_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/frame_rise_det.sv
module frame_rise_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lrck_i,
  output logic rise_o
);
  logic lrck_q;

  // reset high so a frame clock already high is not seen as an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lrck_q <= 1'b1;
    else         lrck_q <= lrck_i;
  end

  assign rise_o = lrck_i & ~lrck_q;
endmodule

// File: rtl/init_counter.sv
module init_counter #(
  parameter int TERM  = 516,
  parameter int CNT_W = $clog2(TERM + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] TermC = CNT_W'(TERM);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (clr_i)                   cnt_q <= '0;
    else if (step_i && cnt_q != TermC) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign done_o = (cnt_q == TermC);

  AST_CNT_SATURATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= TermC); // R4
  AST_CNT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0); // R9
  AST_CNT_SINGLE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(clr_i) && cnt_q != $past(cnt_q)) |-> cnt_q == $past(cnt_q) + 1'b1); // R4
endmodule

// File: rtl/pin_override.sv
module pin_override (
  input  logic pd_i,
  input  logic adc_valid_i,
  input  logic master_i,
  input  logic sdto_i,
  input  logic lrck_i,
  input  logic bclk_i,
  output logic sdto_o,
  output logic lrck_o,
  output logic bclk_o,
  output logic clk_oe_o
);
  logic force_clk;

  always_comb begin
    force_clk = pd_i & master_i;
    sdto_o    = adc_valid_i ? sdto_i : 1'b0;
    lrck_o    = force_clk ? 1'b1 : lrck_i;
    bclk_o    = force_clk ? 1'b0 : bclk_i;
    clk_oe_o  = master_i;
  end
endmodule

// File: rtl/codec_pd_seq.sv
module codec_pd_seq
  import codec_pd_pkg::*;
#(
  parameter int INIT_FRAMES = 516,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(INIT_FRAMES + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pdn_ni,
  input  logic       master_i,
  input  logic       mclk_i,
  input  logic       lrck_i,
  input  logic       bclk_i,
  input  logic       sdto_i,
  output logic       mclk_o,
  output logic       lrck_o,
  output logic       bclk_o,
  output logic       clk_oe_o,
  output logic       sdto_o,
  output logic       adc_filt_rst_o,
  output logic       dac_filt_rst_o,
  output logic       dac_en_o,
  output logic       adc_valid_o,
  output logic [1:0] state_o
);
  pd_state_e        state_q, state_d;
  logic             pdn_s, frame_rise, cnt_done, in_pd;
  logic [CNT_W-1:0] init_cnt;

  pd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pdn_ni), .q_o(pdn_s)
  );

  frame_rise_det u_rise (
    .clk_i(clk_i), .rst_ni(rst_ni), .lrck_i(lrck_i), .rise_o(frame_rise)
  );

  init_counter #(.TERM(INIT_FRAMES), .CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .clr_i(state_q != ST_INIT),
    .step_i(frame_rise),
    .cnt_o(init_cnt), .done_o(cnt_done)
  );

  always_comb begin
    state_d = state_q;
    if (!pdn_s) begin
      state_d = ST_PD;
    end else begin
      unique case (state_q)
        ST_PD:     state_d = ST_INIT;
        ST_INIT:   if (cnt_done) state_d = ST_NORMAL;
        ST_NORMAL: state_d = ST_NORMAL;
        default:   state_d = ST_PD;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_PD;
    else         state_q <= state_d;
  end

  assign in_pd          = (state_q == ST_PD);
  assign adc_valid_o    = (state_q == ST_NORMAL);
  assign adc_filt_rst_o = in_pd;
  assign dac_filt_rst_o = in_pd;
  assign dac_en_o       = ~in_pd;
  assign state_o        = state_q;
  assign mclk_o         = mclk_i;

  pin_override u_pins (
    .pd_i(in_pd), .adc_valid_i(adc_valid_o), .master_i(master_i),
    .sdto_i(sdto_i), .lrck_i(lrck_i), .bclk_i(bclk_i),
    .sdto_o(sdto_o), .lrck_o(lrck_o), .bclk_o(bclk_o), .clk_oe_o(clk_oe_o)
  );

  AST_NORMAL_VIA_INIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_NORMAL |-> $past(state_q) != ST_PD); // R10
  AST_VALID_AT_TERM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(adc_valid_o) |-> $past(init_cnt) == CNT_W'(INIT_FRAMES)); // R4
  AST_SDTO_MUTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adc_valid_o |-> !sdto_o); // R3
  AST_MASTER_PD_LEVELS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PD && master_i) |-> (lrck_o && !bclk_o)); // R6
  AST_DAC_DURING_INIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_INIT |-> (dac_en_o && !dac_filt_rst_o && !adc_valid_o)); // R5
endmodule

// File: tb/codec_pd_seq_test.sv
module codec_pd_seq_test;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic pdn_ni = 1'b1, master_i = 1'b1, mclk_i = 1'b0;
  logic lrck_i = 1'b0, bclk_i = 1'b0, sdto_i = 1'b0;
  logic mclk_o, lrck_o, bclk_o, clk_oe_o, sdto_o;
  logic adc_filt_rst_o, dac_filt_rst_o, dac_en_o, adc_valid_o;
  logic [1:0] state_o;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  codec_pd_seq uut (
    .clk_i(clk), .rst_ni(rst_ni), .pdn_ni(pdn_ni), .master_i(master_i),
    .mclk_i(mclk_i), .lrck_i(lrck_i), .bclk_i(bclk_i), .sdto_i(sdto_i),
    .mclk_o(mclk_o), .lrck_o(lrck_o), .bclk_o(bclk_o), .clk_oe_o(clk_oe_o),
    .sdto_o(sdto_o), .adc_filt_rst_o(adc_filt_rst_o),
    .dac_filt_rst_o(dac_filt_rst_o), .dac_en_o(dac_en_o),
    .adc_valid_o(adc_valid_o), .state_o(state_o)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  // n full frame periods: rise, 4 clk high, 4 clk low
  task automatic frames(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) lrck_i = 1'b1;
      wait_clk(4);
      lrck_i = 1'b0;
      wait_clk(3);
    end
  endtask

  task automatic t_reset;
    sdto_i = 1'b1;
    #1;
    check("R1 state", state_o, 0);
    check("R1 adc_filt_rst", adc_filt_rst_o, 1);
    check("R1 dac_filt_rst", dac_filt_rst_o, 1);
    check("R1 dac_en", dac_en_o, 0);
    check("R1 adc_valid", adc_valid_o, 0);
    check("R1 sdto", sdto_o, 0);
  endtask

  task automatic t_master_pd;
    master_i = 1'b1; lrck_i = 1'b0; bclk_i = 1'b1;
    #1;
    check("R6 lrck forced", lrck_o, 1);
    check("R6 bclk forced", bclk_o, 0);
    check("R7 oe master", clk_oe_o, 1);
    mclk_i = 1'b1; #1;
    check("R8 mclk high in pd", mclk_o, 1);
    mclk_i = 1'b0; #1;
    check("R8 mclk low in pd", mclk_o, 0);
    bclk_i = 1'b0;
  endtask

  task automatic t_slave_pd;
    master_i = 1'b0; lrck_i = 1'b0; bclk_i = 1'b1;
    #1;
    check("R7 slave lrck follows", lrck_o, 0);
    check("R7 slave bclk follows", bclk_o, 1);
    check("R7 oe slave", clk_oe_o, 0);
    check("R3 sdto low in pd", sdto_o, 0);
    lrck_i = 1'b1; bclk_i = 1'b0; #1;
    check("R7 slave lrck follows hi", lrck_o, 1);
    check("R7 slave bclk follows lo", bclk_o, 0);
    lrck_i = 1'b0; master_i = 1'b1;
  endtask

  task automatic t_wakeup;
    @(negedge clk) pdn_ni = 1'b1;
    wait_clk(4);
    check("R10 init code", state_o, 1);
    check("R5 dac_en in init", dac_en_o, 1);
    check("R5 dac_filt_rst released", dac_filt_rst_o, 0);
    check("R5 adc_filt_rst released", adc_filt_rst_o, 0);
    check("R5 adc_valid low", adc_valid_o, 0);
    sdto_i = 1'b1;
    frames(515);
    check("R4 after 515 still init", state_o, 1);
    check("R4 valid low at 515", adc_valid_o, 0);
    check("R3 sdto zero in init", sdto_o, 0);
    bclk_i = 1'b1; #1;
    check("R6 bclk follows in init", bclk_o, 1);
    bclk_i = 1'b0;
    frames(1);
    check("R4 valid after 516", adc_valid_o, 1);
    check("R10 normal code", state_o, 2);
    check("R3 sdto passes high", sdto_o, 1);
    sdto_i = 1'b0; #1;
    check("R3 sdto passes low", sdto_o, 0);
    lrck_i = 1'b1; #1;
    check("R6 lrck follows in normal", lrck_o, 1);
    lrck_i = 1'b0;
  endtask

  task automatic t_pd_from_normal;
    @(negedge clk) pdn_ni = 1'b0;
    wait_clk(4);
    check("R2 state pd", state_o, 0);
    check("R2 adc_filt_rst", adc_filt_rst_o, 1);
    check("R2 dac_filt_rst", dac_filt_rst_o, 1);
    check("R2 dac_en low", dac_en_o, 0);
    sdto_i = 1'b1; #1;
    check("R3 sdto low after pd", sdto_o, 0);
    sdto_i = 1'b0;
  endtask

  task automatic t_abort;
    @(negedge clk) pdn_ni = 1'b1;
    wait_clk(4);
    frames(300);
    check("R9 init before abort", state_o, 1);
    @(negedge clk) pdn_ni = 1'b0;
    wait_clk(4);
    check("R9 abort to pd", state_o, 0);
    @(negedge clk) pdn_ni = 1'b1;
    wait_clk(4);
    check("R9 init again", state_o, 1);
    frames(515);
    check("R9 full window restarts", adc_valid_o, 0);
    frames(1);
    check("R9 valid after full restart", adc_valid_o, 1);
  endtask

  initial begin
    pdn_ni = 1'b0;
    wait_clk(2);
    t_reset();
    @(negedge clk) rst_ni = 1'b1;
    wait_clk(4);
    check("R1 pd after reset", state_o, 0);
    t_master_pd();
    t_slave_pd();
    t_wakeup();
    t_pd_from_normal();
    t_abort();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule